// File: doc/BRIEF.md
# Serial-Loaded DAC Input Register

This block sits in front of a voltage-output converter core. It takes a three-wire serial link (active-low select, serial clock and serial data), brings those pins into the system clock domain and finds their edges there. It builds a 16-bit word most significant bit first and, when the select line is released, moves that word into the code latch that drives the converter. The latch can also be forced to a default code in two ways: by a system reset, or at once by an active-low clear pin that needs no clock. The default is zero for the unipolar build and midscale for the bipolar build.

The converter resolution is a parameter of 16, 14 or 12 bits. The code is always taken from the top of the 16-bit frame. The published code is 16 bits wide, left-justified, and the unused low positions read as zero. Each change of the latch is marked by a one-cycle update strobe. This strobe is a valid with no ready: a converter core cannot hold off its own code, so there is no back-pressure, and the consumer must take the code in the cycle the strobe is high. A frame that ends with fewer than 16 clock edges is rejected and reported on an error pulse.

Top module: `dac_serial_front`

## Requirements
- R1: After reset the code output is the default for the mode, the update strobe is low and the frame error is low. The default is 0x0000 when unipolar and 0x8000 when bipolar: MSB set, all other bits clear, for every resolution.
- R2: While select is low, each rising serial clock edge shifts in one data bit, MSB first. When select goes high after exactly 16 edges, the code output takes that word and the update strobe pulses once.
- R3: If a frame has more than 16 rising edges, the word loaded is the last 16 bits received.
- R4: If a frame has fewer than 16 rising edges, the code does not change, no update strobe is given and the frame error pulses once.
- R5: Serial clock edges that occur while select is high change neither the code, the strobe nor the error output.
- R6: At 14-bit or 12-bit resolution the code is the top 14 or 12 bits of the frame, and the lowest 2 or 4 bits of the code output read as 0.
- R7: A low level on the clear pin forces the code output to the mode default with no clock edge needed. One update strobe follows each clear assertion.
- R8: A select release that falls while clear is low is dropped. After clear is released the code still holds the default. The strobe pulses only for the clear.
- R9: The update strobe and the frame error are each high for exactly one cycle per event. The code changes only in a cycle where the strobe is high or clear is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; serial pins are sampled on it |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| clr_n | input | 1 | Active-low asynchronous clear of the code latch |
| sel_n | input | 1 | Active-low frame select; its rising edge loads the latch |
| sck | input | 1 | Serial clock; data taken on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| dac_code | output | 16 | Latched code, left-justified, unused low bits zero |
| code_upd | output | 1 | One-cycle strobe marking a latch change |
| frame_err | output | 1 | One-cycle pulse when a frame ended short and was rejected |

## Verification
The clear pin and the select release can fall in the same cycle. Both try to set the latch, and clear must win. The bench loads a non-default word, then sends a full valid frame and pulls clear low before releasing select. It releases clear only after the load would have taken place. It judges the result by three things: the code after release must equal the mode default and not the frame, exactly one strobe must have appeared, and a later frame must load normally.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int FRAME_W = 16;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  // Mask keeping the top RES bits of a frame
  function automatic logic [FRAME_W-1:0] res_mask(input int res);
    logic [FRAME_W-1:0] m;
    for (int i = 0; i < FRAME_W; i++) m[i] = (i >= FRAME_W - res);
    return m;
  endfunction

  // Default code after reset or clear
  function automatic logic [FRAME_W-1:0] dflt_code(input bit bipolar);
    logic [FRAME_W-1:0] c;
    c = '0;
    c[FRAME_W-1] = bipolar;
    return c;
  endfunction
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter
  import dacfe_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_s,
  input  logic               sck_s,
  input  logic               sdi_s,
  output logic               load,
  output logic               short_frm,
  output logic [FRAME_W-1:0] word
);
  logic             sel_q, sck_q;
  logic [CNT_W-1:0] nbits;
  logic             sck_rise, sel_fall, sel_rise;

  assign sck_rise = sck_s & ~sck_q;
  assign sel_fall = ~sel_s & sel_q;
  assign sel_rise = sel_s & ~sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b1;
      sck_q     <= 1'b0;
      word      <= '0;
      nbits     <= '0;
      load      <= 1'b0;
      short_frm <= 1'b0;
    end else begin
      sel_q     <= sel_s;
      sck_q     <= sck_s;
      load      <= sel_rise;
      short_frm <= sel_rise & (nbits < CNT_W'(FRAME_W));
      if (sel_fall) begin
        nbits <= '0;
      end else if (!sel_s && sck_rise) begin
        word <= {word[FRAME_W-2:0], sdi_s};
        if (nbits != CNT_W'(FRAME_W)) nbits <= nbits + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dacfe_latch.sv
module dacfe_latch
  import dacfe_pkg::*;
#(
  parameter int RES_BITS = 16,
  parameter bit BIPOLAR  = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_n,
  input  logic               clr_s,
  input  logic               load,
  input  logic               short_frm,
  input  logic [FRAME_W-1:0] word,
  output logic [FRAME_W-1:0] code,
  output logic               upd,
  output logic               err
);
  localparam logic [FRAME_W-1:0] MASK = res_mask(RES_BITS);
  localparam logic [FRAME_W-1:0] DFLT = dflt_code(BIPOLAR);

  logic               latch_rst_n;
  logic [FRAME_W-1:0] held;
  logic               clr_q;

  assign latch_rst_n = rst_n & clr_n;

  always_ff @(posedge clk or negedge latch_rst_n) begin
    if (!latch_rst_n)           held <= DFLT;
    else if (load && !short_frm) held <= word & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= 1'b1;
      upd   <= 1'b0;
      err   <= 1'b0;
    end else begin
      clr_q <= clr_s;
      upd   <= (load & ~short_frm & clr_s) | (clr_q & ~clr_s);
      err   <= load & short_frm;
    end
  end

  assign code = held;
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dacfe_pkg::*;
#(
  parameter int RES_BITS    = 16,
  parameter bit BIPOLAR     = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_n,
  input  logic        sel_n,
  input  logic        sck,
  input  logic        sdi,
  output logic [15:0] dac_code,
  output logic        code_upd,
  output logic        frame_err
);
  logic [3:0]         raw, synced;
  logic               load, short_frm, upd_d, err_d;
  logic [FRAME_W-1:0] word, code;

  assign raw = {clr_n, sel_n, sck, sdi};

  dacfe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  dacfe_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .sel_s(synced[2]), .sck_s(synced[1]), .sdi_s(synced[0]),
    .load(load), .short_frm(short_frm), .word(word)
  );

  dacfe_latch #(.RES_BITS(RES_BITS), .BIPOLAR(BIPOLAR)) u_latch (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .clr_s(synced[3]),
    .load(load), .short_frm(short_frm), .word(word),
    .code(code), .upd(upd_d), .err(err_d)
  );

  assign dac_code  = code;
  assign code_upd  = upd_d;
  assign frame_err = err_d;
endmodule

// File: rtl/dac_front_chk.sv
module dac_front_chk #(
  parameter int RES_BITS = 16,
  parameter bit BIPOLAR  = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        clr_n,
  input logic [15:0] dac_code,
  input logic        code_upd,
  input logic        frame_err
);
  localparam logic [15:0] DFLT = {BIPOLAR, 15'd0};

  a_r7_clear_forces_default: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> dac_code == DFLT);

  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    code_upd |=> !code_upd);

  a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  a_r4_err_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !code_upd);

  a_r9_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && $past(clr_n) && !code_upd) |-> $stable(dac_code));
endmodule

bind dac_serial_front dac_front_chk #(.RES_BITS(RES_BITS), .BIPOLAR(BIPOLAR)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
  .dac_code(dac_code), .code_upd(code_upd), .frame_err(frame_err)
);

// File: tb/sim_dac_serial_front.sv
module sim_dac_serial_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0, clr_n = 1'b1, sel_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [15:0] code0, code1;
  logic upd0, upd1, err0, err1;
  int n_checks = 0, n_fail = 0;
  int cnt_upd0 = 0, cnt_upd1 = 0, cnt_err0 = 0, cnt_err1 = 0;
  logic [15:0] exp0 = 16'h0000, exp1 = 16'h8000;
  bit done = 0;

  always #2.5 clk = ~clk;

  dac_serial_front u0 (.clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sel_n(sel_n),
    .sck(sck), .sdi(sdi), .dac_code(code0), .code_upd(upd0), .frame_err(err0));

  dac_serial_front #(.RES_BITS(12), .BIPOLAR(1'b1)) u1 (.clk(clk), .rst_n(rst_n),
    .clr_n(clr_n), .sel_n(sel_n), .sck(sck), .sdi(sdi), .dac_code(code1),
    .code_upd(upd1), .frame_err(err1));

  always @(posedge clk) begin
    if (upd0) cnt_upd0++;
    if (upd1) cnt_upd1++;
    if (err0) cnt_err0++;
    if (err1) cnt_err1++;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mask12(input logic [15:0] w);
    return w & 16'hFFF0;
  endfunction

  // n edges, bits[n-1] sent first
  task automatic frame(input int n, input logic [31:0] bits, input bit do_release);
    sel_n = 1'b0;
    clks(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      clks(4);
      sck = 1'b1;
      clks(4);
      sck = 1'b0;
    end
    clks(4);
    if (do_release) begin
      sel_n = 1'b1;
      clks(10);
    end
  endtask

  task automatic run_frame(input string req, input int n, input logic [31:0] bits);
    int u0s, u1s, e0s;
    u0s = cnt_upd0; u1s = cnt_upd1; e0s = cnt_err0;
    frame(n, bits, 1'b1);
    if (n >= 16) begin
      exp0 = bits[15:0];
      exp1 = mask12(bits[15:0]);
      check({req, " strobes"}, 16'(cnt_upd0 - u0s), 16'd1);
      check({req, " err"}, 16'(cnt_err0 - e0s), 16'd0);
    end else begin
      check({req, " R4 no strobe"}, 16'(cnt_upd0 - u0s), 16'd0);
      check({req, " R4 err pulse"}, 16'(cnt_err0 - e0s), 16'd1);
    end
    check({req, " code u0"}, code0, exp0);
    check({req, " R6 code u1"}, code1, exp1);
    check({req, " u1 strobes"}, 16'(cnt_upd1 - u1s), (n >= 16) ? 16'd1 : 16'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int u0s, e0s;
    void'($urandom(32'd20240611));
    clks(10);
    // R1 reset state
    check("R1 code u0", code0, 16'h0000);
    check("R1 code u1", code1, 16'h8000);
    check("R1 strobe", {14'd0, upd0, upd1}, 16'd0);
    check("R1 err", {14'd0, err0, err1}, 16'd0);
    rst_n = 1'b1;
    clks(6);
    check("R1 code after release", code0, 16'h0000);

    // R2 exact frame
    run_frame("R2 full", 16, 32'h0000_A5C3);
    run_frame("R2 full b", 16, 32'h0000_1234);
    // R3 long frame
    run_frame("R3 long", 21, 32'h001F_0F17);
    // R4 short frame
    run_frame("R4 short", 9, 32'h0000_01FF);
    run_frame("R4 empty", 0, 32'h0);
    // R6 reduced-resolution low bits
    run_frame("R6 lowbits", 16, 32'h0000_FFFF);

    // R5 clock activity while select high
    u0s = cnt_upd0; e0s = cnt_err0;
    for (int i = 0; i < 10; i++) begin
      sdi = i[0]; clks(3); sck = 1'b1; clks(3); sck = 1'b0;
    end
    clks(10);
    check("R5 code held", code0, exp0);
    check("R5 no strobe", 16'(cnt_upd0 - u0s), 16'd0);
    check("R5 no err", 16'(cnt_err0 - e0s), 16'd0);

    // R7 asynchronous clear
    u0s = cnt_upd0;
    @(posedge clk); #1;
    clr_n = 1'b0;
    #1;
    check("R7 async code u0", code0, 16'h0000);
    check("R7 async code u1", code1, 16'h8000);
    clks(6);
    clr_n = 1'b1;
    clks(8);
    exp0 = 16'h0000; exp1 = 16'h8000;
    check("R7 code after release", code0, exp0);
    check("R7 one strobe", 16'(cnt_upd0 - u0s), 16'd1);

    // R8 clear and select release together
    run_frame("R8 preload", 16, 32'h0000_7E81);
    u0s = cnt_upd0;
    frame(16, 32'h0000_C0DE, 1'b0);
    clr_n = 1'b0;
    clks(6);
    sel_n = 1'b1;
    clks(8);
    clr_n = 1'b1;
    clks(10);
    exp0 = 16'h0000; exp1 = 16'h8000;
    check("R8 code u0", code0, exp0);
    check("R8 code u1", code1, exp1);
    check("R8 clear strobe only", 16'(cnt_upd0 - u0s), 16'd1);
    run_frame("R8 recovery", 16, 32'h0000_3C5A);

    // random frames
    for (int k = 0; k < 40; k++) begin
      int n;
      n = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 24)) : 16;
      run_frame("R2 R3 R4 random", n, $urandom());
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end
endmodule